// File: doc/BRIEF.md
# Flash Chunked Program and Read Sequencer

This block sits between a request source and a single-command serial flash engine. A request names an operation code, a 24-bit start address and a byte count for each direction. The block checks the request, breaks its payload into short pieces of at most four bytes, and drives one engine command per step. Program data arrives on a byte stream and read data leaves on another.

A program piece runs as a fixed bracket: the block gathers the piece's bytes, sends a write-enable command, sends the program command, and then repeats a status read until the flash reports itself idle. A read piece is a single command, and the block then hands the returned bytes out one per cycle. After each piece the address moves on by the piece's size. A one-cycle done pulse with an error flag closes every request. The request source must wait for that pulse before it offers the next request.

Top module: `flash_chunk_seq`

## Requirements
- R1: After reset, cmd_valid, done, wdata_ready and rdata_valid are all low.
- R2: Only opcodes 0x02 (program), 0x03 (read) and 0x0B (fast read) are accepted. Any other opcode gives done with done_err=1 in the cycle after req_valid, with no engine command and no write byte taken.
- R3: A request is rejected like an unknown opcode when its payload direction does not match its opcode: a program with a non-zero read count, or a read with a non-zero write count. This covers any request that has both counts non-zero.
- R4: The payload is cut into pieces of min(remaining, 4) bytes. The program command for a piece carries cmd_op=0x02, cmd_tx_len=3+n (address bytes plus data bytes after the opcode) and cmd_rx_len=0. Its cmd_wdata holds the piece's stream bytes little-endian, with the first byte in bits 7:0 and unused upper bytes zero. Once cmd_valid is high it stays high, with a stable command, until cmd_ready.
- R5: Every program piece is preceded by its own write-enable command: cmd_op=0x06, cmd_tx_len=0, cmd_rx_len=0.
- R6: After every program piece a status read is issued: cmd_op=0x05, cmd_tx_len=0, cmd_rx_len=1. It is repeated while bit 0 of eng_rdata (busy) is 1. Other status bits are ignored.
- R7: cmd_addr of each program or read command equals the request address plus the bytes of all earlier pieces, modulo 2^24.
- R8: A read piece is one command with cmd_op=0x03, cmd_tx_len=3 and cmd_rx_len=n, and it has no write-enable or status step. Byte i of its result (eng_rdata bits 8i+7:8i) leaves on rdata in order of i, one per rdata_valid cycle.
- R9: A fast-read request (0x0B) runs exactly as a plain read: its commands carry opcode 0x03 and no dummy byte.
- R10: done pulses for one cycle with done_err=0 once both counts are used up after a piece: after the final clear status read for a program, or after the last read byte.
- R11: wdata_ready is high only while the bytes of a program piece are being gathered. It is never high together with cmd_valid. Exactly the write count's worth of stream bytes is taken per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, only while idle |
| req_opcode | input | 8 | Requested operation code |
| req_addr | input | ADDR_W | Start address |
| req_wr_len | input | LEN_W | Bytes to program |
| req_rd_len | input | LEN_W | Bytes to read |
| done | output | 1 | Request finished pulse |
| done_err | output | 1 | Request was rejected |
| wdata_valid | input | 1 | Write stream byte present |
| wdata | input | 8 | Write stream byte |
| wdata_ready | output | 1 | Write stream byte taken |
| rdata_valid | output | 1 | Read stream byte present |
| rdata | output | 8 | Read stream byte |
| cmd_valid | output | 1 | Engine command present |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 8 | Command opcode |
| cmd_addr | output | ADDR_W | Command address |
| cmd_tx_len | output | TXW | Bytes sent after the opcode |
| cmd_rx_len | output | TXW | Bytes to receive |
| cmd_wdata | output | 8*CHUNK_BYTES | Program data, little-endian |
| eng_done | input | 1 | Engine finished the accepted command |
| eng_rdata | input | 8*CHUNK_BYTES | Received bytes, little-endian |

## Verification
The write stream can offer a byte in the same cycle that the block is busy with a status read or a write-enable. Such a byte must stay in the stream and become the first byte of the next piece. The bench provokes this by keeping wdata_valid high without a break and stretching the polling with several busy replies, while cmd_ready toggles every cycle. It judges the result by comparing each program command's data word with the stream bytes in order, by counting the bytes consumed per request, and by counting any cycle in which wdata_ready and cmd_valid are high together.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam int ADDR_BYTES = 3;
  localparam int BUSY_BIT   = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_CHUNK, S_FILL, S_WREN_GO, S_WREN_WAIT, S_DATA_GO,
    S_DATA_WAIT, S_DRAIN, S_POLL_GO, S_POLL_WAIT, S_FINISH
  } seq_state_e;

  // Size of the next piece: never more than the cap.
  function automatic int unsigned take_bytes(int unsigned remaining, int unsigned cap);
    return (remaining > cap) ? cap : remaining;
  endfunction

  // Bytes sent after the opcode by a program command.
  function automatic int unsigned prog_tx_bytes(int unsigned n);
    return ADDR_BYTES + n;
  endfunction
endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [7:0]       opcode,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [LEN_W-1:0] rd_len,
  output logic             is_prog,
  output logic             bad,
  output logic [7:0]       eng_op
);
  logic is_read;

  always_comb begin
    is_prog = (opcode == OP_PROG);
    is_read = (opcode == OP_READ) || (opcode == OP_FREAD);
    // a fast read becomes a plain read; no dummy byte goes out
    eng_op  = is_prog ? OP_PROG : OP_READ;
    bad     = !(is_prog || is_read)
            || (is_prog && (rd_len != '0))
            || (is_read && (wr_len != '0));
  end
endmodule

// File: rtl/flash_seq_pack.sv
module flash_seq_pack #(
  parameter int CHUNK_BYTES = 4,
  localparam int NW     = $clog2(CHUNK_BYTES + 1),
  localparam int WORD_W = CHUNK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [7:0]        byte_in,
  output logic [WORD_W-1:0] word_out,
  output logic [NW-1:0]     count_out
);
  logic [WORD_W-1:0] word_q;
  logic [NW-1:0]     cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      for (int i = 0; i < CHUNK_BYTES; i++) begin
        if (cnt_q == NW'(i)) word_q[i*8 +: 8] <= byte_in;
      end
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_out  = word_q;
  assign count_out = cnt_q;
endmodule

// File: rtl/flash_seq_unpack.sv
module flash_seq_unpack #(
  parameter int CHUNK_BYTES = 4,
  localparam int NW     = $clog2(CHUNK_BYTES + 1),
  localparam int WORD_W = CHUNK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [NW-1:0]     count_in,
  input  logic              pop,
  output logic [7:0]        byte_out,
  output logic              empty
);
  logic [WORD_W-1:0] word_q;
  logic [NW-1:0]     left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else if (load) begin
      word_q <= word_in;
      left_q <= count_in;
    end else if (pop && (left_q != '0)) begin
      word_q <= word_q >> 8;
      left_q <= left_q - 1'b1;
    end
  end

  assign byte_out = word_q[7:0];
  assign empty    = (left_q == '0);
endmodule

// File: rtl/flash_chunk_seq.sv
module flash_chunk_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 4,
  localparam int NW     = $clog2(CHUNK_BYTES + 1),
  localparam int TXW    = $clog2(ADDR_BYTES + CHUNK_BYTES + 1),
  localparam int WORD_W = CHUNK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_opcode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_wr_len,
  input  logic [LEN_W-1:0]  req_rd_len,
  output logic              done,
  output logic              done_err,
  input  logic              wdata_valid,
  input  logic [7:0]        wdata,
  output logic              wdata_ready,
  output logic              rdata_valid,
  output logic [7:0]        rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [TXW-1:0]    cmd_tx_len,
  output logic [TXW-1:0]    cmd_rx_len,
  output logic [WORD_W-1:0] cmd_wdata,
  input  logic              eng_done,
  input  logic [WORD_W-1:0] eng_rdata
);
  seq_state_e        state_q;
  logic              prog_q;
  logic [7:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [NW-1:0]     chunk_n_q;
  logic              err_q;

  // decoder
  logic       dec_prog, dec_bad;
  logic [7:0] dec_op;

  flash_seq_decode #(.LEN_W(LEN_W)) u_decode (
    .opcode (req_opcode),
    .wr_len (req_wr_len),
    .rd_len (req_rd_len),
    .is_prog(dec_prog),
    .bad    (dec_bad),
    .eng_op (dec_op)
  );

  // named events
  logic req_take, cmd_fire, data_done_evt, poll_done_evt, poll_clear;
  logic fill_full, drain_end, chunk_end;
  logic [NW-1:0] next_take;
  logic [LEN_W-1:0] req_len;

  // write gathering and read draining
  logic [WORD_W-1:0] pack_word;
  logic [NW-1:0]     fill_cnt;
  logic              pack_clear, pack_take;
  logic [7:0]        unp_byte;
  logic              unp_empty, unp_load, unp_pop;

  flash_seq_pack #(.CHUNK_BYTES(CHUNK_BYTES)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pack_clear),
    .take     (pack_take),
    .byte_in  (wdata),
    .word_out (pack_word),
    .count_out(fill_cnt)
  );

  flash_seq_unpack #(.CHUNK_BYTES(CHUNK_BYTES)) u_unpack (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (unp_load),
    .word_in (eng_rdata),
    .count_in(chunk_n_q),
    .pop     (unp_pop),
    .byte_out(unp_byte),
    .empty   (unp_empty)
  );

  always_comb begin
    req_take      = (state_q == S_IDLE) && req_valid;
    req_len       = dec_prog ? req_wr_len : req_rd_len;
    cmd_fire      = cmd_valid && cmd_ready;
    data_done_evt = (state_q == S_DATA_WAIT) && eng_done;
    poll_done_evt = (state_q == S_POLL_WAIT) && eng_done;
    poll_clear    = poll_done_evt && !eng_rdata[BUSY_BIT];
    fill_full     = (state_q == S_FILL) && (fill_cnt == chunk_n_q);
    drain_end     = (state_q == S_DRAIN) && unp_empty;
    chunk_end     = poll_clear || drain_end;
    next_take     = NW'(take_bytes(32'(rem_q), CHUNK_BYTES));
    pack_clear    = (state_q == S_CHUNK);
    wdata_ready   = (state_q == S_FILL) && (fill_cnt < chunk_n_q);
    pack_take     = wdata_ready && wdata_valid;
    unp_load      = data_done_evt && !prog_q;
    rdata_valid   = (state_q == S_DRAIN) && !unp_empty;
    rdata         = unp_byte;
    unp_pop       = rdata_valid;
    done          = (state_q == S_FINISH);
    done_err      = done && err_q;
  end

  // command fields
  always_comb begin
    cmd_valid  = (state_q == S_WREN_GO) || (state_q == S_DATA_GO) || (state_q == S_POLL_GO);
    cmd_op     = 8'h00;
    cmd_tx_len = '0;
    cmd_rx_len = '0;
    cmd_wdata  = '0;
    cmd_addr   = addr_q;
    unique case (state_q)
      S_WREN_GO: cmd_op = OP_WREN;
      S_POLL_GO: begin
        cmd_op     = OP_RDSR;
        cmd_rx_len = TXW'(1);
      end
      S_DATA_GO: begin
        cmd_op = op_q;
        if (prog_q) begin
          cmd_tx_len = TXW'(prog_tx_bytes(32'(chunk_n_q)));
          cmd_wdata  = pack_word;
        end else begin
          cmd_tx_len = TXW'(ADDR_BYTES);
          cmd_rx_len = TXW'(chunk_n_q);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      prog_q    <= 1'b0;
      op_q      <= 8'h00;
      addr_q    <= '0;
      rem_q     <= '0;
      chunk_n_q <= '0;
      err_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_take) begin
          err_q <= dec_bad;
          if (dec_bad) begin
            state_q <= S_FINISH;
          end else begin
            prog_q  <= dec_prog;
            op_q    <= dec_op;
            addr_q  <= req_addr;
            rem_q   <= req_len;
            state_q <= S_CHUNK;
          end
        end
        S_CHUNK: begin
          chunk_n_q <= next_take;
          rem_q     <= rem_q - LEN_W'(next_take);
          state_q   <= prog_q ? S_FILL : S_DATA_GO;
        end
        S_FILL:      if (fill_full) state_q <= S_WREN_GO;
        S_WREN_GO:   if (cmd_fire) state_q <= S_WREN_WAIT;
        S_WREN_WAIT: if (eng_done) state_q <= S_DATA_GO;
        S_DATA_GO:   if (cmd_fire) state_q <= S_DATA_WAIT;
        S_DATA_WAIT: if (data_done_evt) begin
          addr_q  <= addr_q + ADDR_W'(chunk_n_q);
          state_q <= prog_q ? S_POLL_GO : S_DRAIN;
        end
        S_POLL_GO:   if (cmd_fire) state_q <= S_POLL_WAIT;
        S_POLL_WAIT: if (poll_done_evt && !poll_clear) state_q <= S_POLL_GO;
        S_FINISH:    state_q <= S_IDLE;
        default:     ;
      endcase
      if (chunk_end) state_q <= (rem_q == '0) ? S_FINISH : S_CHUNK;
    end
  end

  // assertions
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_wdata));

  assert_wren_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_WREN) |-> (cmd_tx_len == '0) && (cmd_rx_len == '0));

  assert_poll_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_RDSR) |-> (cmd_tx_len == '0) && (cmd_rx_len == TXW'(1)));

  assert_poll_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done_evt && eng_rdata[BUSY_BIT] |=> cmd_valid && (cmd_op == OP_RDSR));

  assert_read_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_READ) |-> (cmd_tx_len == TXW'(ADDR_BYTES)) && (cmd_rx_len <= TXW'(CHUNK_BYTES)));

  assert_no_fast_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != OP_FREAD));

  assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_take && dec_bad |=> done && done_err);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_stream_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_ready |-> !cmd_valid && !rdata_valid);
endmodule

// File: tb/flash_chunk_seq_test.sv
module flash_chunk_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int LW = 16;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [15:0] wl;
    logic [15:0] rl;
    logic [3:0]  busy;
    logic        err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 24'h001000, 16'd4, 16'd0, 4'd0, 1'b0},
    '{8'h02, 24'h00FFFE, 16'd6, 16'd0, 4'd2, 1'b0},
    '{8'h02, 24'h000200, 16'd1, 16'd0, 4'd1, 1'b0},
    '{8'h03, 24'h000100, 16'd0, 16'd9, 4'd0, 1'b0},
    '{8'h0B, 24'h123456, 16'd0, 16'd5, 4'd0, 1'b0},
    '{8'h03, 24'h000050, 16'd0, 16'd4, 4'd0, 1'b0},
    '{8'h20, 24'h000000, 16'd0, 16'd0, 4'd0, 1'b1},
    '{8'h02, 24'h000010, 16'd3, 16'd2, 4'd0, 1'b1},
    '{8'h03, 24'h000010, 16'd1, 16'd0, 4'd0, 1'b1},
    '{8'h02, 24'hFFFFFC, 16'd8, 16'd0, 4'd3, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_opcode = 8'h00;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_wr_len = '0, req_rd_len = '0;
  logic done, done_err, wdata_ready, rdata_valid, cmd_valid;
  logic [7:0] wdata, rdata, cmd_op;
  logic wdata_valid = 1'b1;
  logic cmd_ready;
  logic [AW-1:0] cmd_addr;
  logic [2:0] cmd_tx_len, cmd_rx_len;
  logic [31:0] cmd_wdata;
  logic eng_done;
  logic [31:0] eng_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_chunk_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .req_wr_len(req_wr_len), .req_rd_len(req_rd_len),
    .done(done), .done_err(done_err), .wdata_valid(wdata_valid), .wdata(wdata),
    .wdata_ready(wdata_ready), .rdata_valid(rdata_valid), .rdata(rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_tx_len(cmd_tx_len), .cmd_rx_len(cmd_rx_len), .cmd_wdata(cmd_wdata),
    .eng_done(eng_done), .eng_rdata(eng_rdata)
  );

  function automatic logic [7:0] stream_byte(int k);
    return 8'((k * 13 + 5) & 255);
  endfunction
  function automatic logic [7:0] flash_byte(logic [AW-1:0] a);
    return 8'((int'(a) * 7 + 3) & 255);
  endfunction

  // write stream source, never pauses
  int wr_idx = 0;
  assign wdata = stream_byte(wr_idx);

  // engine model, logs and observers
  int busy_cfg = 0;
  int poll_seen = 0;
  int pend = 0;
  logic rdy_q = 1'b0;
  logic [31:0] resp_q = '0;
  int ncmd = 0, nrd = 0, done_cnt = 0, overlap = 0;
  logic last_err = 1'b0;
  logic [7:0]    l_op [512];
  logic [AW-1:0] l_addr [512];
  logic [2:0]    l_tx [512], l_rx [512];
  logic [31:0]   l_wd [512];
  logic [7:0]    l_rd [512];

  assign cmd_ready = rdy_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      pend     <= 0;
      eng_done <= 1'b0;
      eng_rdata <= '0;
    end else begin
      rdy_q    <= ~rdy_q;
      eng_done <= 1'b0;
      if (pend == 1) begin
        eng_done  <= 1'b1;
        eng_rdata <= resp_q;
      end
      if (pend != 0) pend <= pend - 1;
      if (cmd_valid && cmd_ready) begin
        l_op[ncmd & 511]   <= cmd_op;
        l_addr[ncmd & 511] <= cmd_addr;
        l_tx[ncmd & 511]   <= cmd_tx_len;
        l_rx[ncmd & 511]   <= cmd_rx_len;
        l_wd[ncmd & 511]   <= cmd_wdata;
        ncmd <= ncmd + 1;
        pend <= 2;
        if (cmd_op == 8'h05) begin
          resp_q    <= (poll_seen < busy_cfg) ? 32'h3 : 32'h2;
          poll_seen <= poll_seen + 1;
        end else if (cmd_op == 8'h03) begin
          for (int i = 0; i < 4; i++)
            resp_q[i*8 +: 8] <= (i < int'(cmd_rx_len)) ? flash_byte(cmd_addr + AW'(i)) : 8'h00;
        end else begin
          resp_q <= '0;
          if (cmd_op == 8'h02) poll_seen <= 0;
        end
      end
    end
    if (rst_n && wdata_valid && wdata_ready) wr_idx <= wr_idx + 1;
    if (rst_n && rdata_valid) begin
      l_rd[nrd & 511] <= rdata;
      nrd <= nrd + 1;
    end
    if (rst_n && done) begin
      done_cnt <= done_cnt + 1;
      last_err <= done_err;
    end
    if (rst_n && wdata_ready && cmd_valid) overlap <= overlap + 1;
  end

  int total = 0, bad = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(vec_t v);
    logic [7:0]    e_op [64];
    logic [AW-1:0] e_addr [64];
    logic [2:0]    e_tx [64], e_rx [64];
    logic [31:0]   e_wd [64];
    int ne = 0;
    int c0, r0, w0, d0, t;
    logic [AW-1:0] a;
    int rem, n, sidx;
    string rq;
    c0 = ncmd; r0 = nrd; w0 = wr_idx; d0 = done_cnt;
    busy_cfg = int'(v.busy);
    // expected command sequence
    a = v.addr; sidx = w0;
    if (!v.err) begin
      if (v.op == 8'h02) begin
        rem = int'(v.wl);
        do begin
          n = (rem > 4) ? 4 : rem; rem -= n;
          e_op[ne] = 8'h06; e_addr[ne] = a; e_tx[ne] = 0; e_rx[ne] = 0; e_wd[ne] = 0; ne++;
          e_op[ne] = 8'h02; e_addr[ne] = a; e_tx[ne] = 3'(3 + n); e_rx[ne] = 0; e_wd[ne] = 0;
          for (int i = 0; i < n; i++) e_wd[ne][i*8 +: 8] = stream_byte(sidx + i);
          ne++; sidx += n;
          for (int p = 0; p <= int'(v.busy); p++) begin
            e_op[ne] = 8'h05; e_addr[ne] = a + AW'(n); e_tx[ne] = 0; e_rx[ne] = 1; e_wd[ne] = 0; ne++;
          end
          a = a + AW'(n);
        end while (rem > 0);
      end else begin
        rem = int'(v.rl);
        do begin
          n = (rem > 4) ? 4 : rem; rem -= n;
          e_op[ne] = 8'h03; e_addr[ne] = a; e_tx[ne] = 3; e_rx[ne] = 3'(n); e_wd[ne] = 0; ne++;
          a = a + AW'(n);
        end while (rem > 0);
      end
    end
    @(negedge clk);
    req_opcode = v.op; req_addr = v.addr; req_wr_len = v.wl; req_rd_len = v.rl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.err) check(done == 1'b1 && done_err == 1'b1, "R2/R3", "reject pulse next cycle", {done, done_err}, 2'b11);
    t = 0;
    while (done_cnt == d0 && t < 5000) begin @(negedge clk); t++; end
    check(t < 5000, "R10", "done seen before watchdog", t, 0);
    @(negedge clk);
    check(!done, "R10", "done is one cycle", done, 0);
    rq = v.err ? "R2/R3" : "R10";
    check(last_err == v.err, rq, "done_err", last_err, v.err);
    check(ncmd - c0 == ne, v.err ? "R2" : "R5/R6", "command count", ncmd - c0, ne);
    for (int i = 0; i < ne && i < ncmd - c0; i++) begin
      int k = (c0 + i) & 511;
      rq = (e_op[i] == 8'h06) ? "R5" : (e_op[i] == 8'h05) ? "R6" : (e_op[i] == 8'h02) ? "R4" : (v.op == 8'h0B) ? "R9" : "R8";
      check(l_op[k] == e_op[i], rq, "cmd_op", l_op[k], e_op[i]);
      if (e_op[i] == 8'h02 || e_op[i] == 8'h03)
        check(l_addr[k] == e_addr[i], "R7", "cmd_addr", l_addr[k], e_addr[i]);
      check(l_tx[k] == e_tx[i] && l_rx[k] == e_rx[i], rq, "tx/rx len", {l_tx[k], l_rx[k]}, {e_tx[i], e_rx[i]});
      check(l_wd[k] == e_wd[i], "R4", "cmd_wdata", l_wd[k], e_wd[i]);
    end
    check(wr_idx - w0 == int'(v.wl) * int'(!v.err), "R11", "write bytes taken", wr_idx - w0, v.err ? 0 : v.wl);
    check(nrd - r0 == (v.err ? 0 : int'(v.rl)), "R8", "read bytes out", nrd - r0, v.rl);
    for (int i = 0; i < nrd - r0 && !v.err; i++)
      check(l_rd[(r0 + i) & 511] == flash_byte(v.addr + AW'(i)), "R8", "read byte", l_rd[(r0 + i) & 511], flash_byte(v.addr + AW'(i)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!cmd_valid && !done && !wdata_ready && !rdata_valid, "R1", "outputs quiet in reset",
          {cmd_valid, done, wdata_ready, rdata_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!cmd_valid && !done && !wdata_ready && !rdata_valid, "R1", "outputs quiet after reset",
          {cmd_valid, done, wdata_ready, rdata_valid}, 0);
    for (int v = 0; v < NV; v++) run_vec(VECS[v]);
    // directed: long polling with the stream offering bytes the whole time (R6, R11)
    run_vec('{8'h02, 24'h000400, 16'd5, 16'd0, 4'd6, 1'b0});
    // directed: request right after a rejection still runs (R2, R8)
    run_vec('{8'hFF, 24'h000000, 16'd2, 16'd0, 4'd0, 1'b1});
    run_vec('{8'h03, 24'hFFFFFE, 16'd0, 16'd3, 4'd0, 1'b0});
    check(overlap == 0, "R11", "wdata_ready never with cmd_valid", overlap, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule